// File: doc/BRIEF.md
# 8-bit microcoded ALU with status flags

This block is the arithmetic stage of a small two-stage microcoded processor. Each cycle it takes two operand bytes (`opT1`, `opT2`) and a 6-bit operation code. It returns a result byte combinationally. It also offers new status flags to an internal processor status byte (PSW). A 2-bit mask chooses which flags of the PSW are written at the clock edge. Flags that the mask does not select keep their values.

The operation set covers the following:
- Add and subtract, with and without carry. The left operand is always `opT2`.
- Bitwise logic.
- Four rotates of `opT1`.
- A pass-through of `opT1`.
- A restart-vector constant taken from three instruction-register bits.
- Reading back the PSW.
- Complementing or setting the carry.
- Decimal adjust.

Decimal adjust has its own register stage. It is issued on two consecutive cycles, and its result is taken on the second issue.

Two side controls serve increment and decrement sequences:
- One control feeds the aux-carry flag, instead of the carry flag, into the carry input.
- The other forces aux-carry to 1 for the current operation.

A load path overwrites the PSW directly.

Top module: `ucAlu8`

## Requirements
- R1: ADD (001100) gives opT2+opT1 and ADC (001101) gives opT2+opT1+carry-in, both modulo 256. The offered CY is the carry out of bit 7, and the offered AC is the carry out of bit 3.
- R2: SUB (001110) gives opT2−opT1 and SBB (001111) gives opT2−opT1−carry-in. The offered CY is 1 when a borrow out of bit 7 occurs, and the offered AC is 1 when a borrow out of bit 3 occurs.
- R3: AND (000100), OR (000101) and XOR (000111) combine opT1 with opT2, and NOT (000110) gives ~opT1. All four offer CY=0 and AC=0.
- R4: The rotates all act on opT1:
  - 000000 rotates left circularly.
  - 000001 rotates right circularly.
  - 000010 rotates left through the carry-in.
  - 000011 rotates right through the carry-in.

  In every case the offered CY is the bit that is shifted out.
- R5: 010111 returns opT1, 011111 returns 8×irCcc, and 110000 returns the current PSW byte.
- R6: CPC (101100) offers the complement of CY, and SEC (101101) offers CY=1. The result byte of both ops is undefined.
- R7: The PSW layout is as follows:
  - bit 7 is S, the result's bit 7.
  - bit 6 is Z, set when the result is zero.
  - bit 4 is AC.
  - bit 2 is P, set when the result has even parity.
  - bit 0 is CY.
  - bits 5 and 3 always read 0, and bit 1 always reads 1.
- R8: On each clock edge without a load, flagMask[0]=1 writes CY and flagMask[1]=1 writes S, Z, AC and P. Unselected flags hold their values.
- R9: The carry-in is CY, or AC when auxCarrySel=1. auxCarrySet=1 makes AC read as 1 for that operation.
- R10: DAA (101000) issued on two consecutive cycles with the same opT1 gives the decimal-adjusted opT1 on the second cycle. The adjustment is computed from AC and CY as they stood at the first issue. The second issue offers the decimal carry as CY.
- R11: Reset sets the PSW to 0x02. When pswLoad=1, the PSW takes pswIn with bits 5 and 3 forced to 0 and bit 1 forced to 1, regardless of the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opT1 | input | 8 | Right operand, also the operand of unary ops |
| opT2 | input | 8 | Left operand of arithmetic, second operand of logic |
| aluOp | input | 6 | Operation code |
| flagMask | input | 2 | Bit 0 writes CY, bit 1 writes S/Z/AC/P |
| irCcc | input | 3 | Instruction-register field for the restart vector |
| auxCarrySel | input | 1 | Use AC as the carry-in |
| auxCarrySet | input | 1 | Force AC to 1 for this operation |
| pswLoad | input | 1 | Load the PSW from pswIn |
| pswIn | input | 8 | PSW load value |
| result | output | 8 | Result byte |
| psw | output | 8 | Status byte |

## Verification
The bench targets several corner cases, each of which would show up as a wrong result byte or a wrong PSW value:

- **Borrow polarity in subtraction.** A design that stores carry rather than borrow inverts CY after SUB and SBB.
- **The nibble carry and borrow that feed AC.** An error here leaves AC clear on 0x3A+0xC6.
- **The carry source of the through-carry rotates.** Getting it wrong puts the stale bit into the vacated position.
- **Masking of partial PSW writes.** A design that ignores the mask overwrites held flags.
- **The aux-carry increment path.** If it is broken, an add of zero leaves the operand unchanged.
- **The two-issue DAA timing.** A design that adjusts in a single cycle, or that uses flags from the wrong cycle, returns 0x9B instead of 0x01.

// File: rtl/ucAluPkg.sv
package ucAluPkg;
  localparam int DataW = 8;
  localparam int OpW   = 6;
  localparam int CccW  = 3;
  localparam int MaskW = 2;

  typedef enum logic [OpW-1:0] {
    OP_RLC  = 6'b000000, OP_RRC  = 6'b000001,
    OP_RAL  = 6'b000010, OP_RAR  = 6'b000011,
    OP_AND  = 6'b000100, OP_OR   = 6'b000101,
    OP_NOT  = 6'b000110, OP_XOR  = 6'b000111,
    OP_ADD  = 6'b001100, OP_ADC  = 6'b001101,
    OP_SUB  = 6'b001110, OP_SBB  = 6'b001111,
    OP_PASS = 6'b010111, OP_RST  = 6'b011111,
    OP_DAA  = 6'b101000, OP_CPC  = 6'b101100,
    OP_SEC  = 6'b101101, OP_PSW  = 6'b110000
  } aluOpE;

  typedef enum logic [2:0] {
    U_NONE, U_ADD, U_LOGIC, U_ROT, U_PASS, U_RST, U_DAA, U_PSW
  } unitE;

  typedef enum logic [1:0] { CY_KEEP, CY_CPL, CY_SET } cyOpE;

  typedef struct packed {
    unitE       unit;
    logic       subtract;
    logic       useCarry;
    logic [1:0] logicSel;
    logic [1:0] rotSel;
    cyOpE       cyOp;
    logic       cinFromAux;
    logic       forceAc;
  } aluCtrlT;
endpackage

// File: rtl/ucAluCtrl.sv
module ucAluCtrl
  import ucAluPkg::*;
(
  input  logic [OpW-1:0] aluOp,
  input  logic           auxCarrySel,
  input  logic           auxCarrySet,
  output aluCtrlT        ctrl
);
  always_comb begin
    ctrl.unit       = U_NONE;
    ctrl.subtract   = 1'b0;
    ctrl.useCarry   = 1'b0;
    ctrl.logicSel   = aluOp[1:0];
    ctrl.rotSel     = aluOp[1:0];
    ctrl.cyOp       = CY_KEEP;
    ctrl.cinFromAux = auxCarrySel;
    ctrl.forceAc    = auxCarrySet;
    case (aluOp)
      OP_ADD:  ctrl.unit = U_ADD;
      OP_ADC:  begin ctrl.unit = U_ADD; ctrl.useCarry = 1'b1; end
      OP_SUB:  begin ctrl.unit = U_ADD; ctrl.subtract = 1'b1; end
      OP_SBB:  begin ctrl.unit = U_ADD; ctrl.subtract = 1'b1; ctrl.useCarry = 1'b1; end
      OP_AND, OP_OR, OP_NOT, OP_XOR: ctrl.unit = U_LOGIC;
      OP_RLC, OP_RRC, OP_RAL, OP_RAR: ctrl.unit = U_ROT;
      OP_PASS: ctrl.unit = U_PASS;
      OP_RST:  ctrl.unit = U_RST;
      OP_DAA:  ctrl.unit = U_DAA;
      OP_CPC:  begin ctrl.unit = U_PASS; ctrl.cyOp = CY_CPL; end
      OP_SEC:  begin ctrl.unit = U_PASS; ctrl.cyOp = CY_SET; end
      OP_PSW:  ctrl.unit = U_PSW;
      default: ctrl.unit = U_NONE;
    endcase
  end
endmodule

// File: rtl/ucAluDatapath.sv
module ucAluDatapath
  import ucAluPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [DataW-1:0] t1,
  input  logic [DataW-1:0] t2,
  input  logic [CccW-1:0]  irCcc,
  input  logic [MaskW-1:0] flagMask,
  input  logic             pswLoad,
  input  logic [DataW-1:0] pswIn,
  input  aluCtrlT          ctrl,
  output logic [DataW-1:0] result,
  output logic [DataW-1:0] psw
);
  localparam int NibW = DataW / 2;
  localparam int BitS = DataW - 1;
  localparam int BitZ = DataW - 2;
  localparam int BitA = NibW;
  localparam int BitP = 2;
  localparam int BitC = 0;
  localparam int RstPad = DataW - CccW - 3;
  localparam logic [DataW-1:0] PswFixed = 8'h02;
  localparam logic [DataW-1:0] PswFree  = 8'hD5;
  localparam logic [NibW-1:0]  BcdNine  = 4'd9;
  localparam logic [NibW-1:0]  BcdSix   = 4'd6;

  logic [DataW-1:0] pswQ;
  logic cyQ, acQ, acEff, cin, carryUsed;
  logic [DataW:0] sumAdd, sumSub, daaSum;
  logic [NibW:0]  lowAdd, lowSub, daaLow;
  logic [DataW-1:0] res;
  logic cyNext, acNext;

  // decimal adjust: first issue registers the correction
  logic loAdj, hiAdj, daaCyD, daaCyQ;
  logic [DataW-1:0] adjD, adjQ;

  assign cyQ = pswQ[BitC];
  assign acQ = pswQ[BitA];
  assign acEff = ctrl.forceAc | acQ;
  assign cin = ctrl.cinFromAux ? acEff : cyQ;
  assign carryUsed = ctrl.useCarry & cin;

  assign sumAdd = {1'b0, t2} + {1'b0, t1} + {{DataW{1'b0}}, carryUsed};
  assign lowAdd = {1'b0, t2[NibW-1:0]} + {1'b0, t1[NibW-1:0]} + {{NibW{1'b0}}, carryUsed};
  assign sumSub = {1'b0, t2} - {1'b0, t1} - {{DataW{1'b0}}, carryUsed};
  assign lowSub = {1'b0, t2[NibW-1:0]} - {1'b0, t1[NibW-1:0]} - {{NibW{1'b0}}, carryUsed};

  always_comb begin
    loAdj = (t1[NibW-1:0] > BcdNine) || acQ;
    hiAdj = (t1[DataW-1:NibW] > BcdNine) || cyQ ||
            ((t1[DataW-1:NibW] >= BcdNine) && (t1[NibW-1:0] > BcdNine));
    adjD = {(hiAdj ? BcdSix : '0), (loAdj ? BcdSix : '0)};
    daaCyD = hiAdj;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      adjQ   <= '0;
      daaCyQ <= 1'b0;
    end else begin
      adjQ   <= adjD;
      daaCyQ <= daaCyD;
    end
  end

  assign daaSum = {1'b0, t1} + {1'b0, adjQ};
  assign daaLow = {1'b0, t1[NibW-1:0]} + {1'b0, adjQ[NibW-1:0]};

  always_comb begin
    res = '0;
    cyNext = cyQ;
    acNext = 1'b0;
    case (ctrl.unit)
      U_ADD: begin
        if (ctrl.subtract) begin
          res = sumSub[DataW-1:0]; cyNext = sumSub[DataW]; acNext = lowSub[NibW];
        end else begin
          res = sumAdd[DataW-1:0]; cyNext = sumAdd[DataW]; acNext = lowAdd[NibW];
        end
      end
      U_LOGIC: begin
        cyNext = 1'b0;
        case (ctrl.logicSel)
          2'd0: res = t1 & t2;
          2'd1: res = t1 | t2;
          2'd2: res = ~t1;
          default: res = t1 ^ t2;
        endcase
      end
      U_ROT: begin
        case (ctrl.rotSel)
          2'd0: begin res = {t1[DataW-2:0], t1[DataW-1]}; cyNext = t1[DataW-1]; end
          2'd1: begin res = {t1[0], t1[DataW-1:1]};       cyNext = t1[0]; end
          2'd2: begin res = {t1[DataW-2:0], cin};         cyNext = t1[DataW-1]; end
          default: begin res = {cin, t1[DataW-1:1]};      cyNext = t1[0]; end
        endcase
      end
      U_PASS: begin
        res = t1;
        case (ctrl.cyOp)
          CY_CPL:  cyNext = ~cyQ;
          CY_SET:  cyNext = 1'b1;
          default: cyNext = cyQ;
        endcase
      end
      U_RST: res = {{RstPad{1'b0}}, irCcc, 3'b000};
      U_DAA: begin
        res = daaSum[DataW-1:0]; cyNext = daaCyQ; acNext = daaLow[NibW];
      end
      U_PSW: res = pswQ;
      default: res = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pswQ <= PswFixed;
    end else if (pswLoad) begin
      pswQ <= (pswIn & PswFree) | PswFixed;
    end else begin
      if (flagMask[0]) pswQ[BitC] <= cyNext;
      if (flagMask[1]) begin
        pswQ[BitS] <= res[DataW-1];
        pswQ[BitZ] <= (res == '0);
        pswQ[BitA] <= acNext;
        pswQ[BitP] <= ~^res;
      end
    end
  end

  assign result = res;
  assign psw = pswQ;

  p_cy_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!pswLoad && !flagMask[0]) |=> $stable(pswQ[BitC]));
  p_flags_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!pswLoad && !flagMask[1]) |=> $stable(pswQ[DataW-1:1]));
  p_load_r11: assert property (@(posedge clk) disable iff (!rstN)
    pswLoad |=> (pswQ == (($past(pswIn) & PswFree) | PswFixed)));
  p_sec_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!pswLoad && flagMask[0] && ctrl.unit == U_PASS && ctrl.cyOp == CY_SET) |=> pswQ[BitC]);
  p_cpc_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!pswLoad && flagMask[0] && ctrl.unit == U_PASS && ctrl.cyOp == CY_CPL)
      |=> (pswQ[BitC] != $past(pswQ[BitC])));
  p_fixed_bits_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!pswQ[5] && !pswQ[3] && pswQ[1]));
endmodule

// File: rtl/ucAlu8.sv
module ucAlu8
  import ucAluPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [DataW-1:0] opT1,
  input  logic [DataW-1:0] opT2,
  input  logic [OpW-1:0]   aluOp,
  input  logic [MaskW-1:0] flagMask,
  input  logic [CccW-1:0]  irCcc,
  input  logic             auxCarrySel,
  input  logic             auxCarrySet,
  input  logic             pswLoad,
  input  logic [DataW-1:0] pswIn,
  output logic [DataW-1:0] result,
  output logic [DataW-1:0] psw
);
  aluCtrlT ctrl;

  ucAluCtrl uCtrl (
    .aluOp(aluOp), .auxCarrySel(auxCarrySel), .auxCarrySet(auxCarrySet), .ctrl(ctrl)
  );

  ucAluDatapath uDp (
    .clk(clk), .rstN(rstN), .t1(opT1), .t2(opT2), .irCcc(irCcc),
    .flagMask(flagMask), .pswLoad(pswLoad), .pswIn(pswIn), .ctrl(ctrl),
    .result(result), .psw(psw)
  );
endmodule

// File: tb/tb_ucAlu8.sv
`timescale 1ns/1ps
module tb_ucAlu8;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] opT1 = '0, opT2 = '0, pswIn = '0;
  logic [5:0] aluOp = 6'b010111;
  logic [1:0] flagMask = '0;
  logic [2:0] irCcc = '0;
  logic auxCarrySel = 1'b0, auxCarrySet = 1'b0, pswLoad = 1'b0;
  logic [7:0] result, psw;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ucAlu8 dut (
    .clk(clk), .rstN(rstN), .opT1(opT1), .opT2(opT2), .aluOp(aluOp),
    .flagMask(flagMask), .irCcc(irCcc), .auxCarrySel(auxCarrySel),
    .auxCarrySet(auxCarrySet), .pswLoad(pswLoad), .pswIn(pswIn),
    .result(result), .psw(psw)
  );

  typedef struct packed {
    logic [5:0] op; logic [7:0] t1; logic [7:0] t2; logic [2:0] ir;
    logic [1:0] mask; logic sel; logic set; logic [7:0] pre;
    logic chk; logic [7:0] res; logic [7:0] pswX; logic [3:0] req;
  } vecT;

  localparam int NV = 23;
  localparam vecT VECS [NV] = '{
    '{6'b001100, 8'hC6, 8'h3A, 3'd0, 2'd3, 1'b0, 1'b0, 8'h02, 1'b1, 8'h00, 8'h57, 4'd1}, // R1 ADD wrap
    '{6'b001101, 8'h05, 8'h10, 3'd0, 2'd3, 1'b0, 1'b0, 8'h03, 1'b1, 8'h16, 8'h02, 4'd1}, // R1 ADC
    '{6'b001110, 8'h07, 8'h05, 3'd0, 2'd3, 1'b0, 1'b0, 8'h02, 1'b1, 8'hFE, 8'h93, 4'd2}, // R2 SUB borrow
    '{6'b001111, 8'h20, 8'h50, 3'd0, 2'd3, 1'b0, 1'b0, 8'h03, 1'b1, 8'h2F, 8'h12, 4'd2}, // R2 SBB
    '{6'b000100, 8'hF0, 8'h3C, 3'd0, 2'd3, 1'b0, 1'b0, 8'h13, 1'b1, 8'h30, 8'h06, 4'd3}, // R3 AND
    '{6'b000101, 8'h81, 8'h02, 3'd0, 2'd3, 1'b0, 1'b0, 8'h02, 1'b1, 8'h83, 8'h82, 4'd3}, // R3 OR
    '{6'b000111, 8'hAA, 8'hAA, 3'd0, 2'd3, 1'b0, 1'b0, 8'h02, 1'b1, 8'h00, 8'h46, 4'd3}, // R3 XOR
    '{6'b000110, 8'h0F, 8'h00, 3'd0, 2'd3, 1'b0, 1'b0, 8'h03, 1'b1, 8'hF0, 8'h86, 4'd3}, // R3 NOT
    '{6'b000000, 8'h81, 8'h00, 3'd0, 2'd1, 1'b0, 1'b0, 8'h02, 1'b1, 8'h03, 8'h03, 4'd4}, // R4 rot left circ
    '{6'b000001, 8'h01, 8'h00, 3'd0, 2'd1, 1'b0, 1'b0, 8'h02, 1'b1, 8'h80, 8'h03, 4'd4}, // R4 rot right circ
    '{6'b000010, 8'h80, 8'h00, 3'd0, 2'd1, 1'b0, 1'b0, 8'h03, 1'b1, 8'h01, 8'h03, 4'd4}, // R4 rot left thru carry
    '{6'b000011, 8'h02, 8'h00, 3'd0, 2'd1, 1'b0, 1'b0, 8'h03, 1'b1, 8'h81, 8'h02, 4'd4}, // R4 rot right thru carry
    '{6'b010111, 8'h5A, 8'h00, 3'd0, 2'd0, 1'b0, 1'b0, 8'hD7, 1'b1, 8'h5A, 8'hD7, 4'd5}, // R5 pass
    '{6'b011111, 8'h33, 8'h00, 3'd5, 2'd0, 1'b0, 1'b0, 8'h02, 1'b1, 8'h28, 8'h02, 4'd5}, // R5 restart vector
    '{6'b110000, 8'h00, 8'h00, 3'd0, 2'd0, 1'b0, 1'b0, 8'h97, 1'b1, 8'h97, 8'h97, 4'd5}, // R5 PSW read
    '{6'b101100, 8'h00, 8'h00, 3'd0, 2'd1, 1'b0, 1'b0, 8'h03, 1'b0, 8'h00, 8'h02, 4'd6}, // R6 CPC
    '{6'b101101, 8'h00, 8'h00, 3'd0, 2'd1, 1'b0, 1'b0, 8'h02, 1'b0, 8'h00, 8'h03, 4'd6}, // R6 SEC
    '{6'b001100, 8'h01, 8'hFF, 3'd0, 2'd1, 1'b0, 1'b0, 8'h02, 1'b1, 8'h00, 8'h03, 4'd8}, // R8 CY only
    '{6'b001100, 8'h01, 8'hFF, 3'd0, 2'd2, 1'b0, 1'b0, 8'h02, 1'b1, 8'h00, 8'h56, 4'd8}, // R8 others only
    '{6'b001100, 8'h01, 8'hFF, 3'd0, 2'd0, 1'b0, 1'b0, 8'h82, 1'b1, 8'h00, 8'h82, 4'd8}, // R8 none
    '{6'b001101, 8'h00, 8'h00, 3'd0, 2'd3, 1'b1, 1'b0, 8'h12, 1'b1, 8'h01, 8'h02, 4'd9}, // R9 AC as carry
    '{6'b001101, 8'h7F, 8'h00, 3'd0, 2'd3, 1'b1, 1'b1, 8'h02, 1'b1, 8'h80, 8'h92, 4'd9}, // R9 forced AC inc
    '{6'b001100, 8'h01, 8'h02, 3'd0, 2'd3, 1'b0, 1'b0, 8'h02, 1'b1, 8'h03, 8'h06, 4'd7}  // R7 even parity
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic presetPsw(input logic [7:0] v);
    @(negedge clk);
    pswLoad = 1'b1; pswIn = v; flagMask = 2'd0; aluOp = 6'b010111;
    @(negedge clk);
    pswLoad = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R11 reset", psw, 8'h02);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      presetPsw(VECS[i].pre);
      aluOp = VECS[i].op; opT1 = VECS[i].t1; opT2 = VECS[i].t2; irCcc = VECS[i].ir;
      flagMask = VECS[i].mask; auxCarrySel = VECS[i].sel; auxCarrySet = VECS[i].set;
      #1;
      if (VECS[i].chk) check($sformatf("R%0d result v%0d", VECS[i].req, i), result, VECS[i].res);
      @(negedge clk);
      flagMask = 2'd0; auxCarrySel = 1'b0; auxCarrySet = 1'b0; aluOp = 6'b010111;
      check($sformatf("R%0d psw v%0d", VECS[i].req, i), psw, VECS[i].pswX);
    end

    // R10 decimal adjust, two issues: 0x9B -> 0x01 with CY, AC
    presetPsw(8'h02);
    aluOp = 6'b101000; opT1 = 8'h9B; flagMask = 2'd0;
    @(negedge clk);
    flagMask = 2'd3;
    #1 check("R10 daa result 9B", result, 8'h01);
    @(negedge clk);
    aluOp = 6'b010111; flagMask = 2'd0;
    check("R10 daa psw 9B", psw, 8'h13);

    // R10 low-nibble adjust driven by AC: 0x15 -> 0x1B
    presetPsw(8'h12);
    aluOp = 6'b101000; opT1 = 8'h15; flagMask = 2'd0;
    @(negedge clk);
    flagMask = 2'd3;
    #1 check("R10 daa result 15", result, 8'h1B);
    @(negedge clk);
    aluOp = 6'b010111; flagMask = 2'd0;
    check("R10 daa psw 15", psw, 8'h06);

    // R11 load forces fixed bits
    presetPsw(8'hFF);
    check("R11 load fixed bits", psw, 8'hD7);

    // R11 load wins over a masked SEC
    @(negedge clk);
    pswLoad = 1'b1; pswIn = 8'h00; aluOp = 6'b101101; flagMask = 2'd3;
    @(negedge clk);
    pswLoad = 1'b0; flagMask = 2'd0; aluOp = 6'b010111;
    check("R11 load priority", psw, 8'h02);

    // R11 reset mid-run
    presetPsw(8'hD7);
    rstN = 1'b0;
    @(negedge clk);
    check("R11 reset mid-run", psw, 8'h02);
    rstN = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule